// File: doc/BRIEF.md
# Parallel ADC Bus Sequencer

This block runs a complete acquisition on a 10-bit converter that sits on a parallel bus and is addressed like a memory device. One start pulse from user logic makes it do the following steps in order:

- lower the active-low chip select;
- pulse the write strobe; the converter samples and starts converting when write goes high again;
- wait for the active-low end-of-conversion line to fall;
- pulse the read strobe and take the 10-bit word off the bus on the last cycle before read is released;
- hold chip select for a programmed time;
- wait until end-of-conversion has gone high again, because the read re-arms it.

Only then does the block accept another request. The converter times its own conversion, so the block supplies no conversion clock and only waits.

All setup, width, access and hold intervals are parameters counted in system clock cycles. End-of-conversion comes from another timing domain and passes through a two-flop synchronizer. The block puts a bound on both waits. If end-of-conversion does not fall, or does not come back high, within the set number of cycles, the block does three things:

- it releases every strobe;
- it sets an error flag that stays set until reset;
- it returns to idle.

Top module: `adcseq_ctrl`

## Requirements
- R1: After reset, chip select, write and read are high (inactive), and busy, valid and error are low.
- R2: A start pulse seen while idle raises busy on the next cycle. Chip select is low for exactly CS_SETUP cycles before write goes low. While idle with no start, busy stays low.
- R3: Write is low for exactly WR_LOW cycles. Chip select is low whenever write is low, and is still low in the first cycle after write rises.
- R4: Write and read are never low together. Read is low only while chip select is low, and read stays low for exactly RD_ACC cycles.
- R5: The data word is sampled on the last read-low cycle. Valid is high for exactly one cycle, and data_o carries that word while valid is high.
- R6: After read rises, chip select stays low for exactly 1 + CS_HOLD cycles before it rises.
- R7: Write never goes low while the converter's end-of-conversion is low. Busy falls only after the synchronized end-of-conversion is seen high following the read.
- R8: Suppose end-of-conversion stays high for EOC_TIMEOUT cycles after the block enters its wait. Then error goes high exactly EOC_TIMEOUT+1 cycles after write rises, busy falls, all strobes go high and no valid pulse is produced. Error stays high until reset.
- R9: A start pulse that arrives while busy is ignored, so the number of valid pulses equals the number of starts accepted while idle.
- R10: End-of-conversion is synchronized through two flops. Read goes low exactly 3 cycles after a falling end-of-conversion edge is presented between clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one acquisition (honoured only when idle) |
| busy_o | output | 1 | High from acceptance of start until return to idle |
| valid_o | output | 1 | One-cycle pulse marking a captured word |
| data_o | output | 10 | Last captured conversion result |
| err_o | output | 1 | Sticky conversion timeout flag |
| adc_cs_n_o | output | 1 | Converter chip select, active low |
| adc_wr_n_o | output | 1 | Converter write strobe, active low |
| adc_rd_n_o | output | 1 | Converter read strobe, active low |
| adc_eoc_n_i | input | 1 | Converter end-of-conversion, low when result is latched |
| adc_data_i | input | 10 | Converter data bus |

## Verification
The assertions assume the following converter behaviour:

- end-of-conversion falls only after a write rising edge;
- it returns high only after a read with chip select low;
- it never changes during a write pulse.

That is why the write-start check can treat a high synchronized level as a precondition. The bench's converter model follows these rules:

- it starts a conversion only on a write release while chip select is low;
- the conversion takes a random 2 to 33 cycles, and re-arm after a read takes a random 0 to 5 cycles;
- it drives the bus with the inverted result until the second read-low cycle.

Random extra start pulses land while the block is busy. A directed long conversion pushes the block into its timeout.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CS_SETUP,
    ST_WR_LOW,
    ST_WR_REL,
    ST_WAIT_EOC,
    ST_RD_LOW,
    ST_CAPTURE,
    ST_CS_HOLD,
    ST_WAIT_REARM
  } seq_state_t;

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned bits_for(input int unsigned v);
    return (v < 1) ? 1 : $clog2(v + 1);
  endfunction

  // chip select low during the whole bus transaction, including the EOC wait
  function automatic logic cs_active(input seq_state_t s);
    return s inside {ST_CS_SETUP, ST_WR_LOW, ST_WR_REL, ST_WAIT_EOC,
                     ST_RD_LOW, ST_CAPTURE, ST_CS_HOLD};
  endfunction

  function automatic logic wr_active(input seq_state_t s);
    return s == ST_WR_LOW;
  endfunction

  function automatic logic rd_active(input seq_state_t s);
    return s == ST_RD_LOW;
  endfunction

endpackage

// File: rtl/adcseq_sync.sv
module adcseq_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= {STAGES{RESET_VAL}};
    else        shreg <= {shreg[STAGES-2:0], d_i};
  end

  assign q_o = shreg[STAGES-1];
endmodule

// File: rtl/adcseq_timer.sv
module adcseq_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/adcseq_fsm.sv
module adcseq_fsm
  import adcseq_pkg::*;
#(
  parameter int unsigned CS_SETUP    = 2,
  parameter int unsigned WR_LOW      = 3,
  parameter int unsigned RD_ACC      = 3,
  parameter int unsigned CS_HOLD     = 2,
  parameter int unsigned EOC_TIMEOUT = 1000,
  parameter int unsigned CNT_W       = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             eoc_n_s_i,
  input  logic             tmr_zero_i,
  output seq_state_t       state_d_o,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             capture_o,
  output logic             timeout_o
);
  seq_state_t state_q, state_d;

  // cycles to spend in a state, minus one, loaded on entry
  function automatic logic [CNT_W-1:0] dwell_of(input seq_state_t s);
    case (s)
      ST_CS_SETUP:   return CNT_W'(CS_SETUP - 1);
      ST_WR_LOW:     return CNT_W'(WR_LOW - 1);
      ST_WAIT_EOC:   return CNT_W'(EOC_TIMEOUT - 1);
      ST_RD_LOW:     return CNT_W'(RD_ACC - 1);
      ST_CS_HOLD:    return CNT_W'(CS_HOLD - 1);
      ST_WAIT_REARM: return CNT_W'(EOC_TIMEOUT - 1);
      default:       return '0;
    endcase
  endfunction

  always_comb begin
    state_d   = state_q;
    capture_o = 1'b0;
    timeout_o = 1'b0;
    case (state_q)
      ST_IDLE:     if (start_i)    state_d = ST_CS_SETUP;
      ST_CS_SETUP: if (tmr_zero_i) state_d = ST_WR_LOW;
      ST_WR_LOW:   if (tmr_zero_i) state_d = ST_WR_REL;
      ST_WR_REL:                   state_d = ST_WAIT_EOC;
      ST_WAIT_EOC: begin
        if (!eoc_n_s_i)            state_d = ST_RD_LOW;
        else if (tmr_zero_i) begin
          state_d   = ST_IDLE;
          timeout_o = 1'b1;
        end
      end
      ST_RD_LOW: begin
        if (tmr_zero_i) begin
          state_d   = ST_CAPTURE;
          capture_o = 1'b1;
        end
      end
      ST_CAPTURE:                  state_d = ST_CS_HOLD;
      ST_CS_HOLD:  if (tmr_zero_i) state_d = ST_WAIT_REARM;
      ST_WAIT_REARM: begin
        if (eoc_n_s_i)             state_d = ST_IDLE;
        else if (tmr_zero_i) begin
          state_d   = ST_IDLE;
          timeout_o = 1'b1;
        end
      end
      default:                     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign tmr_load_o = (state_d != state_q);
  assign tmr_val_o  = dwell_of(state_d);
  assign state_d_o  = state_d;
endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int unsigned DATA_W      = 10,
  parameter int unsigned CS_SETUP    = 2,
  parameter int unsigned WR_LOW      = 3,
  parameter int unsigned RD_ACC      = 3,
  parameter int unsigned CS_HOLD     = 2,
  parameter int unsigned EOC_TIMEOUT = 1000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              busy_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              err_o,
  output logic              adc_cs_n_o,
  output logic              adc_wr_n_o,
  output logic              adc_rd_n_o,
  input  logic              adc_eoc_n_i,
  input  logic [DATA_W-1:0] adc_data_i
);
  localparam int unsigned MAX_DWELL =
    max_of(max_of(max_of(CS_SETUP, WR_LOW), max_of(RD_ACC, CS_HOLD)), EOC_TIMEOUT);
  localparam int unsigned CNT_W = bits_for(MAX_DWELL);

  // named internal events, observed by the bound checker
  logic             eoc_sync;
  logic             ev_timeout;
  logic             ev_capture;
  logic             tmr_load;
  logic             tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  seq_state_t       state_d;

  adcseq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (adc_eoc_n_i),
    .q_o   (eoc_sync)
  );

  adcseq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  adcseq_fsm #(
    .CS_SETUP    (CS_SETUP),
    .WR_LOW      (WR_LOW),
    .RD_ACC      (RD_ACC),
    .CS_HOLD     (CS_HOLD),
    .EOC_TIMEOUT (EOC_TIMEOUT),
    .CNT_W       (CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .eoc_n_s_i  (eoc_sync),
    .tmr_zero_i (tmr_zero),
    .state_d_o  (state_d),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .capture_o  (ev_capture),
    .timeout_o  (ev_timeout)
  );

  // pin-side registers, decoded from the next state so they align with it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adc_cs_n_o <= 1'b1;
      adc_wr_n_o <= 1'b1;
      adc_rd_n_o <= 1'b1;
      busy_o     <= 1'b0;
      valid_o    <= 1'b0;
      err_o      <= 1'b0;
      data_o     <= '0;
    end else begin
      adc_cs_n_o <= ~cs_active(state_d);
      adc_wr_n_o <= ~wr_active(state_d);
      adc_rd_n_o <= ~rd_active(state_d);
      busy_o     <= (state_d != ST_IDLE);
      valid_o    <= ev_capture;
      err_o      <= err_o | ev_timeout;
      if (ev_capture) data_o <= adc_data_i;
    end
  end
endmodule

// File: rtl/adcseq_ctrl_chk.sv
module adcseq_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic valid_o,
  input logic err_o,
  input logic cs_n,
  input logic wr_n,
  input logic rd_n,
  input logic eoc_sync,
  input logic ev_timeout
);
  // R4
  strobe_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!wr_n && !rd_n));

  // R3
  wr_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> !cs_n);

  // R4
  rd_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !cs_n);

  // R5
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  // R8
  timeout_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> (err_o && !busy_o && cs_n && wr_n && rd_n && !valid_o));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> !busy_o);

  // R7
  write_after_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> eoc_sync);

  // R10
  read_after_eoc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> !$past(eoc_sync));
endmodule

bind adcseq_ctrl adcseq_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .valid_o    (valid_o),
  .err_o      (err_o),
  .cs_n       (adc_cs_n_o),
  .wr_n       (adc_wr_n_o),
  .rd_n       (adc_rd_n_o),
  .eoc_sync   (eoc_sync),
  .ev_timeout (ev_timeout)
);

// File: tb/adcseq_ctrl_tb.sv
module adcseq_ctrl_tb;
  localparam int CS_SETUP = 2;
  localparam int WR_LOW   = 3;
  localparam int RD_ACC   = 3;
  localparam int CS_HOLD  = 2;
  localparam int TMO      = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       busy, valid, err, cs_n, wr_n, rd_n;
  logic [9:0] data;
  logic       eoc_m = 1'b1;
  logic [9:0] bus_m = '0;

  always #4 clk = ~clk;

  adcseq_ctrl #(
    .DATA_W(10), .CS_SETUP(CS_SETUP), .WR_LOW(WR_LOW), .RD_ACC(RD_ACC),
    .CS_HOLD(CS_HOLD), .EOC_TIMEOUT(TMO), .SYNC_STAGES(2)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy), .valid_o(valid),
    .data_o(data), .err_o(err), .adc_cs_n_o(cs_n), .adc_wr_n_o(wr_n),
    .adc_rd_n_o(rd_n), .adc_eoc_n_i(eoc_m), .adc_data_i(bus_m)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int conv_cfg = 10, rearm_cfg = 0;
  int conv_cnt = 0, rd_cnt = 0, rearm_cnt = 0;
  bit converting = 0;
  logic [9:0] conv_val = 10'h2A5;
  int accepted = 0, valids = 0;
  int cs_run = 0, wr_run = 0, rd_run = 0, hold_run = 0;
  bit in_hold = 0, err_seen = 0, prev_valid = 0, mon_on = 0;
  logic prev_wr = 1'b1, prev_rd = 1'b1;
  int eoc_fall_cyc = 0, wr_rise_cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_hold_len(input int hold);
    return 1 + hold;
  endfunction

  function automatic int exp_err_delay(input int tmo);
    return tmo + 1;
  endfunction

  // monitor and converter model, both on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      if (prev_wr && !wr_n) begin
        chk(cs_run == CS_SETUP, "R2 cs setup", cs_run, CS_SETUP);
        chk(eoc_m == 1'b1, "R7 write with eoc high", int'(eoc_m), 1);
        wr_run = 0;
      end
      if (!wr_n) wr_run++;
      if (!prev_wr && wr_n) begin
        chk(wr_run == WR_LOW, "R3 write width", wr_run, WR_LOW);
        chk(cs_n == 1'b0, "R3 cs after write", int'(cs_n), 0);
        wr_rise_cyc = cyc;
        if (!cs_n) begin
          converting = 1;
          conv_cnt = conv_cfg;
        end
      end
      if (prev_rd && !rd_n) begin
        chk(cyc - eoc_fall_cyc == 3, "R10 eoc to read", cyc - eoc_fall_cyc, 3);
        rd_run = 0;
      end
      if (!rd_n) rd_run++;
      if (!prev_rd && rd_n) begin
        chk(rd_run == RD_ACC, "R4 read width", rd_run, RD_ACC);
        in_hold = 1;
        hold_run = 0;
      end
      if (in_hold) begin
        if (!cs_n) hold_run++;
        else begin
          chk(hold_run == exp_hold_len(CS_HOLD), "R6 cs hold", hold_run, exp_hold_len(CS_HOLD));
          in_hold = 0;
        end
      end
      if (!wr_n && !rd_n) chk(0, "R4 overlap", 1, 0);
      if (valid) begin
        chk(data == conv_val, "R5 data", int'(data), int'(conv_val));
        chk(!prev_valid, "R5 single pulse", 1, 0);
        valids++;
      end
      if (err && !err_seen) begin
        err_seen = 1;
        chk(cyc - wr_rise_cyc == exp_err_delay(TMO), "R8 timeout delay",
            cyc - wr_rise_cyc, exp_err_delay(TMO));
      end
      if (!cs_n) cs_run++; else cs_run = 0;
      prev_wr = wr_n;
      prev_rd = rd_n;
      prev_valid = valid;
    end
    // converter model
    if (converting) begin
      conv_cnt--;
      if (conv_cnt <= 0) begin
        converting = 0;
        conv_val = 10'($urandom);
        eoc_m = 1'b0;
        eoc_fall_cyc = cyc;
      end
    end
    if (!cs_n && !rd_n) begin
      rd_cnt++;
      if (rd_cnt == 1) begin
        if (rearm_cfg == 0) eoc_m = 1'b1;
        else rearm_cnt = rearm_cfg;
      end
    end else begin
      rd_cnt = 0;
    end
    bus_m = (rd_cnt >= 2) ? conv_val : ~conv_val;
    if (rearm_cnt > 0) begin
      rearm_cnt--;
      if (rearm_cnt == 0) eoc_m = 1'b1;
    end
  end

  task automatic pulse_start();
    bit was_idle;
    @(negedge clk);
    was_idle = !busy;
    if (was_idle) accepted++;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (was_idle) chk(busy == 1'b1, "R2 busy rise", int'(busy), 1);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!busy) return;
    end
  endtask

  task automatic run_one(input int conv, input int rearm, input int pokes);
    conv_cfg = conv;
    rearm_cfg = rearm;
    pulse_start();
    for (int p = 0; p < pokes; p++) begin
      repeat (1 + $urandom % 8) @(negedge clk);
      if (busy) pulse_start();
    end
    wait_idle();
  endtask

  initial begin
    void'($urandom(32'd1550));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cs_n && wr_n && rd_n, "R1 strobes idle", int'({cs_n, wr_n, rd_n}), 7);
    chk(!busy && !valid && !err, "R1 flags low", int'({busy, valid, err}), 0);
    mon_on = 1;
    repeat (5) @(negedge clk);
    chk(!busy, "R2 idle without start", int'(busy), 0);
    // directed corners: fastest conversion, slow re-arm
    run_one(2, 0, 0);
    run_one(2, 10, 0);
    run_one(30, 5, 3);
    // random mix
    for (int k = 0; k < 30; k++)
      run_one(2 + int'($urandom % 32), int'($urandom % 6), int'($urandom % 4));
    repeat (3) @(negedge clk);
    chk(valids == accepted, "R9 starts while busy ignored", valids, accepted);
    chk(!err, "R8 no error on good runs", int'(err), 0);
    // timeout: conversion longer than the window
    run_one(TMO + 50, 0, 0);
    @(negedge clk);
    chk(err == 1'b1, "R8 error set", int'(err), 1);
    chk(!busy && cs_n && wr_n && rd_n, "R8 strobes released", int'({busy, cs_n, wr_n, rd_n}), 7);
    chk(valids == accepted - 1, "R8 no valid on timeout", valids, accepted - 1);
    repeat (120) @(negedge clk);
    chk(err == 1'b1, "R8 error sticky", int'(err), 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule